// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block looks at the state of a bank of shared interrupts that all target one processor and picks the one that should be signalled next. Each interrupt supplies five things: a pending bit, an enable bit, an active bit, an 8-bit priority and a 2-bit group code. A control byte says which groups may fire, and it changes meaning when the security-disable bit is set. The block reports the winning interrupt's ID, priority and group, or reports that no interrupt qualifies.

A query port works alongside the selection. It takes any interrupt ID and returns that interrupt's 2-bit life-cycle status. The selection is a single combinational scan over a configurable number of interrupts. All results are captured in registers, so they follow the inputs with one cycle of latency. Vector bit `i` always stands for interrupt ID `FIRST_ID + i`.

Top module: `prio_pick`

## Requirements
- R1: An interrupt is eligible only when it is pending, enabled, not active and its group is enabled. When no interrupt is eligible, the result is "none".
- R2: Among eligible interrupts, the one with the numerically smallest priority value wins, because a smaller value is more urgent.
- R3: When eligible interrupts share the smallest priority, the one with the lowest ID wins.
- R4: When no interrupt wins, `valid_o` is 0, `id_o` is 1023, `prio_o` is 0xFF and `grp_o` is 0.
- R5: With control bit 6 clear, group enables are as follows:
  - control bit 0 enables group code 0 (secure group 0);
  - control bit 2 enables code 1 (secure group 1);
  - control bit 1 enables code 2 (non-secure group 1);
  - code 3 is never enabled.
- R6: With control bit 6 set, control bit 0 enables code 0 and control bit 1 enables both codes 1 and 2. Control bit 2 has no effect in this mode.
- R7: Vector bit `i` maps to interrupt ID `FIRST_ID + i`. A valid `id_o` always lies in `[FIRST_ID, FIRST_ID+N)`.
- R8: `qry_stat_o` gives the queried interrupt's status as {active, pending}: 00 inactive, 01 pending, 10 active, 11 active-and-pending. An ID outside the bank reads 00.
- R9: All outputs are registered. They reflect the inputs present at the previous rising clock edge. While reset is asserted they hold the "none" values of R4 and status 00.
- R10: An interrupt whose group is disabled is ignored, even at priority 0x00.
- R11: `grp_o` and `prio_o` equal the group code and priority of the winning interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | N | Pending bit per interrupt |
| enab_i | input | N | Enable bit per interrupt |
| act_i | input | N | Active bit per interrupt |
| prio_i | input | 8*N | Priority byte per interrupt, byte i at [8i+7:8i] |
| grp_i | input | 2*N | Group code per interrupt, code i at [2i+1:2i] |
| ctrl_i | input | 8 | Group enables (bits 0,1,2) and security-disable (bit 6) |
| qry_id_i | input | ID_W | Interrupt ID whose status is requested |
| valid_o | output | 1 | A winner exists |
| id_o | output | ID_W | Winning ID, or 1023 |
| prio_o | output | 8 | Winning priority, or 0xFF |
| grp_o | output | 2 | Winning group code, or 0 |
| qry_stat_o | output | 2 | Status of the queried interrupt |

## Verification
Selection and the status query both read the same pending and active vectors in the same cycle. A query aimed at the current winner must therefore return 01 while that interrupt is being reported. A query aimed at an active interrupt must return 10 or 11 while that interrupt is excluded from selection.

The sweep provokes this case by drawing the query ID from a window that covers the whole bank and the IDs just outside it. Every random vector set then gives a cycle in which both results are judged together, against a model that orders eligible interrupts by the pair {priority, index}.

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int unsigned N        = 64,
  parameter int unsigned FIRST_ID = 32,
  parameter int unsigned ID_W     = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    pend_i,
  input  logic [N-1:0]    enab_i,
  input  logic [N-1:0]    act_i,
  input  logic [8*N-1:0]  prio_i,
  input  logic [2*N-1:0]  grp_i,
  input  logic [7:0]      ctrl_i,
  input  logic [ID_W-1:0] qry_id_i,
  output logic            valid_o,
  output logic [ID_W-1:0] id_o,
  output logic [7:0]      prio_o,
  output logic [1:0]      grp_o,
  output logic [1:0]      qry_stat_o
);
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [ID_W-1:0] NONE_ID = ID_W'(1023);

  logic       sec_off;
  logic [3:0] grp_on;
  logic [N-1:0] cand;

  assign sec_off   = ctrl_i[6];
  assign grp_on[0] = ctrl_i[0];
  assign grp_on[1] = sec_off ? ctrl_i[1] : ctrl_i[2];
  assign grp_on[2] = ctrl_i[1];
  assign grp_on[3] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_cand
    assign cand[i] = pend_i[i] & enab_i[i] & ~act_i[i] & grp_on[grp_i[2*i +: 2]];
  end

  logic             hit;
  logic [7:0]       best_pri;
  logic [IDX_W-1:0] best_idx;

  always_comb begin
    hit      = 1'b0;
    best_pri = 8'hFF;
    best_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!hit || prio_i[8*i +: 8] < best_pri)) begin
        hit      = 1'b1;
        best_pri = prio_i[8*i +: 8];
        best_idx = IDX_W'(i);
      end
    end
  end

  logic             q_in;
  logic [IDX_W-1:0] q_idx;
  logic [1:0]       q_stat;

  always_comb begin
    int unsigned q;
    q      = 32'(qry_id_i);
    q_in   = (q >= FIRST_ID) && (q < FIRST_ID + N);
    q_idx  = IDX_W'(q - FIRST_ID);
    q_stat = q_in ? {act_i[q_idx], pend_i[q_idx]} : 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o    <= 1'b0;
      id_o       <= NONE_ID;
      prio_o     <= 8'hFF;
      grp_o      <= 2'b00;
      qry_stat_o <= 2'b00;
    end else begin
      valid_o    <= hit;
      id_o       <= hit ? ID_W'(FIRST_ID) + ID_W'(best_idx) : NONE_ID;
      prio_o     <= hit ? best_pri : 8'hFF;
      grp_o      <= hit ? grp_i[2*best_idx +: 2] : 2'b00;
      qry_stat_o <= q_stat;
    end
  end
endmodule

// File: rtl/prio_pick_chk.sv
module prio_pick_chk #(
  parameter int unsigned N        = 64,
  parameter int unsigned FIRST_ID = 32,
  parameter int unsigned ID_W     = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    pend_i,
  input logic [N-1:0]    enab_i,
  input logic [N-1:0]    act_i,
  input logic [8*N-1:0]  prio_i,
  input logic [2*N-1:0]  grp_i,
  input logic [7:0]      ctrl_i,
  input logic [ID_W-1:0] qry_id_i,
  input logic            valid_o,
  input logic [ID_W-1:0] id_o,
  input logic [7:0]      prio_o,
  input logic [1:0]      grp_o,
  input logic [1:0]      qry_stat_o
);
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

  logic            seen;
  logic [N-1:0]    pend_q, enab_q, act_q;
  logic [8*N-1:0]  prio_q;
  logic [2*N-1:0]  grp_q;
  logic [ID_W-1:0] qry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0; pend_q <= '0; enab_q <= '0; act_q <= '0;
      prio_q <= '0; grp_q <= '0; qry_q <= '0;
    end else begin
      seen <= 1'b1; pend_q <= pend_i; enab_q <= enab_i; act_q <= act_i;
      prio_q <= prio_i; grp_q <= grp_i; qry_q <= qry_id_i;
    end
  end

  logic [IDX_W-1:0] widx, qidx;
  logic             q_in;
  assign widx = IDX_W'(32'(id_o) - FIRST_ID);
  assign qidx = IDX_W'(32'(qry_q) - FIRST_ID);
  assign q_in = (32'(qry_q) >= FIRST_ID) && (32'(qry_q) < FIRST_ID + N);

  // R4
  idle_vals_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (32'(id_o) == 1023 && prio_o == 8'hFF && grp_o == 2'b00));

  // R7
  id_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (32'(id_o) >= FIRST_ID && 32'(id_o) < FIRST_ID + N));

  // R1
  winner_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && valid_o) |-> (pend_q[widx] && enab_q[widx] && !act_q[widx]));

  // R1
  none_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && (pend_q & enab_q & ~act_q) == '0) |-> !valid_o);

  // R11
  winner_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && valid_o) |-> (prio_o == prio_q[8*widx +: 8] && grp_o == grp_q[2*widx +: 2]));

  // R8
  query_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (qry_stat_o == (q_in ? {act_q[qidx], pend_q[qidx]} : 2'b00)));
endmodule

bind prio_pick prio_pick_chk #(.N(N), .FIRST_ID(FIRST_ID), .ID_W(ID_W)) u_chk (.*);

// File: tb/sim_prio_pick.sv
module sim_prio_pick;
  localparam int NB = 8;
  localparam int FB = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0]   pend = '0, enab = '0, act = '0;
  logic [8*NB-1:0] prio = '0;
  logic [2*NB-1:0] grp = '0;
  logic [7:0]      ctrl = '0;
  logic [9:0]      qid = '0;
  logic            valid_o;
  logic [9:0]      id_o;
  logic [7:0]      prio_o;
  logic [1:0]      grp_o, qry_stat_o;

  int checks = 0;
  int errs = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  prio_pick #(.N(NB), .FIRST_ID(FB), .ID_W(10)) u0 (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .enab_i(enab), .act_i(act),
    .prio_i(prio), .grp_i(grp), .ctrl_i(ctrl), .qry_id_i(qid),
    .valid_o(valid_o), .id_o(id_o), .prio_o(prio_o), .grp_o(grp_o),
    .qry_stat_o(qry_stat_o));

  function automatic logic [31:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  function automatic logic gen(logic [1:0] g);
    case (g)
      2'd0: return ctrl[0];
      2'd1: return ctrl[6] ? ctrl[1] : ctrl[2];
      2'd2: return ctrl[1];
      default: return 1'b0;
    endcase
  endfunction

  logic       e_v;
  logic [9:0] e_id;
  logic [7:0] e_p;
  logic [1:0] e_g, e_s;

  task automatic model();
    logic [15:0] best;
    best = 16'hFFFF; e_v = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (pend[i] && enab[i] && !act[i] && gen(grp[2*i +: 2]) &&
          {prio[8*i +: 8], 8'(i)} < best) begin
        best = {prio[8*i +: 8], 8'(i)};
        e_v = 1'b1;
      end
    end
    e_id = e_v ? 10'(FB + int'(best[7:0])) : 10'd1023;
    e_p  = e_v ? best[15:8] : 8'hFF;
    e_g  = e_v ? grp[2*best[7:0] +: 2] : 2'b00;
    if (int'(qid) >= FB && int'(qid) < FB + NB)
      e_s = {act[int'(qid) - FB], pend[int'(qid) - FB]};
    else
      e_s = 2'b00;
  endtask

  task automatic chk(string req, logic [31:0] a, logic [31:0] e);
    checks++;
    if (a !== e) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  task automatic step_cmp(string req);
    model();
    @(posedge clk); @(negedge clk);
    chk({req, " valid"}, 32'(valid_o), 32'(e_v));
    chk({req, " id"}, 32'(id_o), 32'(e_id));
    chk({req, " prio"}, 32'(prio_o), 32'(e_p));
    chk({req, " grp"}, 32'(grp_o), 32'(e_g));
    chk({req, " status"}, 32'(qry_stat_o), 32'(e_s));
  endtask

  task automatic clr();
    pend = '0; enab = '0; act = '0; prio = {NB{8'hFF}}; grp = '0; ctrl = '0; qid = 10'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    clr();
    repeat (2) @(negedge clk);
    // R9 R4 reset values
    chk("R9 reset valid", 32'(valid_o), 0);
    chk("R4 reset id", 32'(id_o), 1023);
    chk("R4 reset prio", 32'(prio_o), 32'hFF);
    chk("R9 reset status", 32'(qry_stat_o), 0);
    rst_n = 1'b1;
    step_cmp("R4 idle");

    // R10 disabled group at priority 0x00
    clr(); pend[3] = 1; enab[3] = 1; prio[8*3 +: 8] = 8'h00; grp[2*3 +: 2] = 2'd0;
    ctrl = 8'h06;
    step_cmp("R10 disabled p0");
    chk("R10 none", 32'(valid_o), 0);
    pend[5] = 1; enab[5] = 1; prio[8*5 +: 8] = 8'h80; grp[2*5 +: 2] = 2'd2;
    step_cmp("R10 other wins");
    chk("R10 id", 32'(id_o), 37);

    // R3 tie
    clr(); ctrl = 8'h07;
    pend = 8'b0010_0100; enab = 8'hFF;
    prio[8*2 +: 8] = 8'h40; prio[8*5 +: 8] = 8'h40;
    step_cmp("R3 tie");
    chk("R3 tie id", 32'(id_o), 34);

    // R2 smaller value wins
    clr(); ctrl = 8'h07; enab = 8'hFF;
    pend[6] = 1; prio[8*6 +: 8] = 8'h10;
    pend[1] = 1; prio[8*1 +: 8] = 8'h20;
    step_cmp("R2 urgency");
    chk("R2 id", 32'(id_o), 38);

    // R9 latency: output holds before the edge
    @(negedge clk);
    pend[6] = 0;
    #1 chk("R9 hold", 32'(id_o), 38);
    step_cmp("R9 update");
    chk("R9 new id", 32'(id_o), 33);

    // R6 security-disabled mode
    clr(); pend[4] = 1; enab[4] = 1; prio[8*4 +: 8] = 8'h30; grp[2*4 +: 2] = 2'd1;
    ctrl = 8'h44;
    step_cmp("R6 bit2 ignored");
    chk("R6 none", 32'(valid_o), 0);
    ctrl = 8'h42;
    step_cmp("R6 bit1 enables");
    chk("R6 id", 32'(id_o), 36);

    // R8 status encodings and out-of-range
    clr(); pend = 8'b0000_0101; act = 8'b0000_0110;
    for (int q = 30; q < 42; q++) begin
      qid = 10'(q);
      step_cmp("R8 query");
    end

    // R5 R6 sweep: one interrupt, every control combo and group code
    for (int c = 0; c < 16; c++) begin
      for (int g = 0; g < 4; g++) begin
        clr(); pend[7] = 1; enab[7] = 1; prio[8*7 +: 8] = 8'h55;
        grp[2*7 +: 2] = 2'(g);
        ctrl = {1'b0, c[3], 3'b000, c[2:0]};
        step_cmp(c[3] ? "R6 sweep" : "R5 sweep");
      end
    end

    // R1 R2 R3 R7 R11 random sweep with concurrent query
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = rnd(); pend = r[7:0]; enab = r[15:8] | r[23:16]; act = r[31:24] & r[7:0] & 8'h55;
      r = rnd(); ctrl = {1'b0, r[6], 3'b000, r[2:0]};
      qid = 10'(28 + int'(r[11:8]) + int'(r[12]));
      r = rnd(); grp = r[15:0];
      for (int i = 0; i < NB; i++) begin
        r = rnd();
        prio[8*i +: 8] = r[2] ? 8'hFF : {r[1:0], 6'h00};
      end
      step_cmp("R1 R2 R3 R7 R11 sweep");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule